// File: doc/BRIEF.md
# Display Control Register Decoder

This block decodes 32-bit writes arriving on a display control port. The top byte of each write is a command code and the lower bits carry its operands. The block keeps a 32-bit display status word and a bank of per-command register slots. Every write whose code fits in the bank is stored in the slot with that index. From the stored slots and the status word, the block derives several values. These are the display start coordinates, the vertical display range, and the active picture width and height.

The block also keeps the odd/even field bit, which is updated on each vertical-blank event. It presents the assembled status word as a combinational read. The top bit of that read follows an external line-parity input, but only while the display is progressive and outside vertical blank. Video timing generation and pixel output belong to other blocks.

Top module: `disp_ctl_decoder`

## Requirements
- R1: After `rst`, and one cycle after a write with code 0x00, bits 30:0 of `status_rd` equal those of 0x14802000, and the field bit (status bit 31) is 0.
- R2: A write whose code is below `NUM_SLOTS` stores the full 32-bit word in slot `code`, which `slot_rd` returns when `slot_sel` selects it. A write with a larger code changes no slot. Slots reset to 0.
- R3: Code 0x03 copies data bit 0 into blanking status bit 23.
- R4: Code 0x04 copies data bits 1:0 into DMA-direction status bits 30:29.
- R5: `disp_x` and `disp_y` follow bits 9:0 and 19:10 of the word last written with code 0x05.
- R6: `vrange_start` and `vrange_end` follow bits 9:0 and 19:10 of the word last written with code 0x07.
- R7: Code 0x08 replaces status bits 22:16. Data bits 5:0 go to status bits 22:17 and data bit 6 goes to status bit 16. Status bit 22 is the interlace flag.
- R8: `act_width` is selected by status bits 18:16, with index 0 to 7 giving 256, 368, 320, 384, 512, 512, 640, 640.
- R9: `act_height` is selected by status bits 20:19, with index 0 to 3 giving 240, 480, 256, 480.
- R10: While interlaced, a vertical-blank event with value 1 inverts the field bit (status bit 31), and one with value 0 leaves it unchanged.
- R11: While progressive, any vertical-blank event clears the field bit.
- R12: Read bit 31 is the field bit ORed with `line_parity`. The `line_parity` term applies only if the display is progressive and the most recent vertical-blank event had value 0. A write with code 0x08 that sets interlace removes the `line_parity` term at once.
- R13: Codes other than 0x00, 0x03, 0x04 and 0x08 leave the status word unchanged. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | One-cycle write strobe |
| ctl_wdata | input | 32 | Write word: code in bits 31:24, operands below |
| vblank_evt | input | 1 | One-cycle vertical-blank event strobe |
| vblank_val | input | 1 | Value carried by the vertical-blank event |
| line_parity | input | 1 | External line-parity bit reported in progressive mode |
| slot_sel | input | SLOT_W (4) | Slot index for `slot_rd` |
| slot_rd | output | 32 | Contents of the selected slot |
| status_rd | output | 32 | Assembled status word |
| disp_x | output | 10 | Display start X |
| disp_y | output | 10 | Display start Y |
| vrange_start | output | 10 | Vertical range start |
| vrange_end | output | 10 | Vertical range end |
| act_width | output | 10 | Active width in pixels |
| act_height | output | 9 | Active height in lines |

## Verification
The bench builds the block with its defaults: 16 slots and 10-bit coordinates. Every status-touching code and all eight width indices therefore fall inside the bank. Code 0x10 shares its low four bits with slot 0, so a write with that code shows whether the full code is compared or only a truncated index. With 10-bit coordinates, the extreme operand bits 9 and 19 are reachable, so a misplaced field split between X and Y shows up in the outputs.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam logic [31:0] STATUS_RST = 32'h1480_2000;

    localparam int BIT_FIELD   = 31;
    localparam int BIT_BLANK   = 23;
    localparam int BIT_ILACE   = 22;
    localparam int DMA_LO      = 29;
    localparam int MODE_LO     = 16;

    localparam logic [7:0] CODE_RESET = 8'h00;
    localparam logic [7:0] CODE_BLANK = 8'h03;
    localparam logic [7:0] CODE_DMA   = 8'h04;
    localparam logic [7:0] CODE_START = 8'h05;
    localparam logic [7:0] CODE_RANGE = 8'h07;
    localparam logic [7:0] CODE_MODE  = 8'h08;

    typedef struct packed {
        logic [31:0] status;
        logic        par_en;
    } dcr_state_t;

endpackage

// File: rtl/dcr_res_lut.sv
module dcr_res_lut (
    input  logic [2:0] wsel,
    input  logic [1:0] hsel,
    output logic [9:0] width,
    output logic [8:0] height
);
    always_comb begin
        case (wsel)
            3'd0:    width = 10'd256;
            3'd1:    width = 10'd368;
            3'd2:    width = 10'd320;
            3'd3:    width = 10'd384;
            3'd4,
            3'd5:    width = 10'd512;
            default: width = 10'd640;
        endcase
    end

    always_comb begin
        case (hsel)
            2'd0:    height = 9'd240;
            2'd2:    height = 9'd256;
            default: height = 9'd480;
        endcase
    end
endmodule

// File: rtl/dcr_slot_bank.sv
module dcr_slot_bank #(
    parameter int NUM_SLOTS = 16,
    parameter int CW        = 10,
    parameter int START_IDX = 5,
    parameter int RANGE_IDX = 7,
    localparam int SW       = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [7:0]    code,
    input  logic [31:0]   wdata,
    input  logic [SW-1:0] rd_sel,
    output logic [31:0]   rd_data,
    output logic [2*CW-1:0] start_word,
    output logic [2*CW-1:0] range_word
);
    logic [NUM_SLOTS-1:0][31:0] slot_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit;
        assign hit = we && (code == 8'(i));
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (hit)
                slot_q[i] <= wdata;
        end
    end

    assign rd_data    = slot_q[rd_sel];
    assign start_word = slot_q[START_IDX][2*CW-1:0];
    assign range_word = slot_q[RANGE_IDX][2*CW-1:0];
endmodule

// File: rtl/disp_ctl_decoder.sv
module disp_ctl_decoder #(
    parameter int NUM_SLOTS = 16,
    parameter int CW        = 10,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_wdata,
    input  logic              vblank_evt,
    input  logic              vblank_val,
    input  logic              line_parity,
    input  logic [SLOT_W-1:0] slot_sel,
    output logic [31:0]       slot_rd,
    output logic [31:0]       status_rd,
    output logic [CW-1:0]     disp_x,
    output logic [CW-1:0]     disp_y,
    output logic [CW-1:0]     vrange_start,
    output logic [CW-1:0]     vrange_end,
    output logic [9:0]        act_width,
    output logic [8:0]        act_height
);
    import dcr_pkg::*;

    logic [7:0] code;
    assign code = ctl_wdata[31:24];

    dcr_state_t st_d, st_q;
    logic [2*CW-1:0] start_word, range_word;

    dcr_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CW        (CW),
        .START_IDX (int'(CODE_START)),
        .RANGE_IDX (int'(CODE_RANGE))
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .code       (code),
        .wdata      (ctl_wdata),
        .rd_sel     (slot_sel),
        .rd_data    (slot_rd),
        .start_word (start_word),
        .range_word (range_word)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            case (code)
                CODE_RESET: st_d.status = STATUS_RST;
                CODE_BLANK: st_d.status[BIT_BLANK] = ctl_wdata[0];
                CODE_DMA:   st_d.status[DMA_LO+1:DMA_LO] = ctl_wdata[1:0];
                CODE_MODE: begin
                    st_d.status[MODE_LO+6:MODE_LO+1] = ctl_wdata[5:0];
                    st_d.status[MODE_LO]             = ctl_wdata[6];
                end
                default: ;
            endcase
        end
        if (vblank_evt) begin
            if (st_d.status[BIT_ILACE]) begin
                if (vblank_val)
                    st_d.status[BIT_FIELD] = ~st_d.status[BIT_FIELD];
                st_d.par_en = 1'b0;
            end else begin
                st_d.status[BIT_FIELD] = 1'b0;
                st_d.par_en            = ~vblank_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.status <= STATUS_RST;
            st_q.par_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    dcr_res_lut u_lut (
        .wsel   (st_q.status[MODE_LO+2:MODE_LO]),
        .hsel   (st_q.status[MODE_LO+4:MODE_LO+3]),
        .width  (act_width),
        .height (act_height)
    );

    assign status_rd = {st_q.status[BIT_FIELD] |
                        (st_q.par_en & ~st_q.status[BIT_ILACE] & line_parity),
                        st_q.status[30:0]};

    assign disp_x       = start_word[CW-1:0];
    assign disp_y       = start_word[2*CW-1:CW];
    assign vrange_start = range_word[CW-1:0];
    assign vrange_end   = range_word[2*CW-1:CW];
endmodule

// File: rtl/disp_ctl_decoder_chk.sv
module disp_ctl_decoder_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          ctl_we,
    input logic [31:0]   ctl_wdata,
    input logic          vblank_evt,
    input logic          vblank_val,
    input logic [31:0]   status_rd,
    input logic [31:0]   status_q,
    input logic [CW-1:0] disp_x,
    input logic [9:0]    act_width,
    input logic [8:0]    act_height
);
    // R1
    reset_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[31:24] == 8'h00 && !vblank_evt)
        |=> (status_rd[30:0] == 31'h1480_2000 && !status_q[31]));

    // R3
    blank_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[31:24] == 8'h03)
        |=> (status_rd[23] == $past(ctl_wdata[0])));

    // R10
    field_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (vblank_evt && vblank_val && status_q[22] && !ctl_we)
        |=> (status_q[31] != $past(status_q[31])));

    // R11
    field_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (vblank_evt && !status_q[22] && !ctl_we)
        |=> !status_q[31]);

    // R8
    size_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> ($stable(act_width) && $stable(act_height)));

    // R5
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl_we && ctl_wdata[31:24] == 8'h05) |=> $stable(disp_x));
endmodule

bind disp_ctl_decoder disp_ctl_decoder_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .vblank_evt (vblank_evt),
    .vblank_val (vblank_val),
    .status_rd  (status_rd),
    .status_q   (st_q.status),
    .disp_x     (disp_x),
    .act_width  (act_width),
    .act_height (act_height)
);

// File: tb/disp_ctl_decoder_bench.sv
module disp_ctl_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        vblank_evt = 1'b0;
    logic        vblank_val = 1'b0;
    logic        line_parity = 1'b0;
    logic [3:0]  slot_sel = '0;
    logic [31:0] slot_rd, status_rd;
    logic [9:0]  disp_x, disp_y, vrange_start, vrange_end, act_width;
    logic [8:0]  act_height;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_ctl_decoder u_disp_ctl_decoder (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .vblank_evt(vblank_evt), .vblank_val(vblank_val),
        .line_parity(line_parity), .slot_sel(slot_sel), .slot_rd(slot_rd),
        .status_rd(status_rd), .disp_x(disp_x), .disp_y(disp_y),
        .vrange_start(vrange_start), .vrange_end(vrange_end),
        .act_width(act_width), .act_height(act_height)
    );

    localparam logic [31:0] VEC_WR [NVEC] = '{
        32'h0300_0000, 32'h0300_0001, 32'h0400_0002, 32'h0400_0003,
        32'h0100_0000, 32'h0800_0047, 32'h0800_003F, 32'h0800_0005,
        32'h0000_0000, 32'h0800_0002, 32'h0800_0008, 32'h0800_0040,
        32'h0800_0041, 32'h0800_0042, 32'h0800_000C };
    localparam logic [31:0] VEC_ST [NVEC] = '{
        32'h1400_2000, 32'h1480_2000, 32'h5480_2000, 32'h7480_2000,
        32'h7480_2000, 32'h748F_2000, 32'h74FE_2000, 32'h748A_2000,
        32'h1480_2000, 32'h1484_2000, 32'h1490_2000, 32'h1481_2000,
        32'h1483_2000, 32'h1485_2000, 32'h1498_2000 };
    localparam logic [9:0] VEC_W [NVEC] = '{
        10'd256, 10'd256, 10'd256, 10'd256, 10'd256, 10'd640, 10'd640,
        10'd320, 10'd256, 10'd512, 10'd256, 10'd368, 10'd384, 10'd512,
        10'd256 };
    localparam logic [8:0] VEC_H [NVEC] = '{
        9'd240, 9'd240, 9'd240, 9'd240, 9'd240, 9'd480, 9'd480,
        9'd480, 9'd240, 9'd240, 9'd256, 9'd240, 9'd240, 9'd240,
        9'd480 };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic vbl(input logic v);
        @(negedge clk);
        vblank_evt = 1'b1;
        vblank_val = v;
        @(negedge clk);
        vblank_evt = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset status", status_rd, 32'h1480_2000);
        check("R8 reset width", 32'(act_width), 32'd256);
        check("R9 reset height", 32'(act_height), 32'd240);
        check("R2 reset slot", slot_rd, 32'h0);

        // R3 R4 R7 R8 R9 R13 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC_WR[i]);
            check("R3/R4/R7/R13 status", status_rd, VEC_ST[i]);
            check("R8 width", 32'(act_width), 32'(VEC_W[i]));
            check("R9 height", 32'(act_height), 32'(VEC_H[i]));
        end

        // R5 start coordinates
        wr(32'h050A_AD23);
        check("R5 disp_x", 32'(disp_x), 32'h123);
        check("R5 disp_y", 32'(disp_y), 32'h2AB);
        slot_sel = 4'd5;
        #1 check("R2 slot 5", slot_rd, 32'h050A_AD23);

        // R6 vertical range
        wr(32'h0704_0010);
        check("R6 vrange_start", 32'(vrange_start), 32'h010);
        check("R6 vrange_end", 32'(vrange_end), 32'h100);

        // R2 code above bank must not alias slot 0
        wr(32'h0000_0000);
        wr(32'h10AB_CDEF);
        slot_sel = 4'd0;
        #1 check("R2 no alias", slot_rd, 32'h0000_0000);
        check("R13 code 0x10 status", status_rd, 32'h1480_2000);

        // R10 interlaced field toggling
        wr(32'h0800_0020);
        vbl(1'b1);
        check("R10 toggle on 1", 32'(status_rd[31]), 32'd1);
        vbl(1'b0);
        check("R10 hold on 0", 32'(status_rd[31]), 32'd1);
        vbl(1'b1);
        check("R10 toggle back", 32'(status_rd[31]), 32'd0);
        vbl(1'b1);
        check("R10 toggle again", 32'(status_rd[31]), 32'd1);

        // R11 progressive clears field
        wr(32'h0800_0000);
        check("R11 field kept until event", 32'(status_rd[31]), 32'd1);
        vbl(1'b1);
        check("R11 field cleared", 32'(status_rd[31]), 32'd0);

        // R12 line parity gating
        line_parity = 1'b1;
        #1 check("R12 parity gated after val 1", 32'(status_rd[31]), 32'd0);
        vbl(1'b0);
        check("R12 parity passes", 32'(status_rd[31]), 32'd1);
        line_parity = 1'b0;
        #1 check("R12 parity follows input", 32'(status_rd[31]), 32'd0);
        line_parity = 1'b1;
        wr(32'h0800_0020);
        check("R12 interlace blocks parity", 32'(status_rd[31]), 32'd0);
        wr(32'h0800_0000);
        vbl(1'b1);
        check("R12 vblank blocks parity", 32'(status_rd[31]), 32'd0);
        line_parity = 1'b0;

        // R1 reset code clears field
        wr(32'h0800_0020);
        vbl(1'b1);
        wr(32'h0000_0000);
        check("R1 code 0 clears field", status_rd, 32'h1480_2000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule